// File: doc/BRIEF.md
# Register Rename Unit with Reorder-Buffer Recovery

This block maps the architectural registers named by an incoming instruction onto a larger pool of physical registers. It also records every in-flight instruction in a reorder buffer (ROB) that holds only bookkeeping and no data values. For each dispatched instruction it returns the physical tags of the two sources, a ready flag for each source, the physical register newly allocated for the destination, and the ROB slot the instruction occupies. Execution units report completion by ROB slot. The block then marks the destination physical register as ready and retires finished instructions strictly in program order. At retirement it hands back the physical register that the destination used to map to, so that register can be allocated again.

Branches take a copy of the rename map when they dispatch. The branch is later resolved by ROB slot. A correct prediction only releases the copy. A misprediction discards every younger entry, moves the allocation pointer back to just after the branch, returns the physical registers those entries had taken, and reloads the map from the copy. The functional units and the register file that holds the data live outside this block.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i and is ready, physical registers 8 to 15 are free, the ROB is empty, the next ROB slot is 0 and no commit is offered.
- R2: A dispatched instruction reads its sources through the current map. A destination takes the lowest-numbered free physical register, and later instructions see the new mapping. ROB slots are handed out in ascending order modulo 8.
- R3: A newly allocated physical register reads as not ready until the instruction that writes it completes.
- R4: A completion report for a live entry makes its destination ready from the next cycle. A dispatch in the same cycle that reads that register already sees it as ready.
- R5: At most one entry commits per cycle, always the oldest and only once it has completed. The commit outputs give its slot, opcode, destination, destination-valid flag and the previous physical mapping. That mapping is free for allocation from the next cycle.
- R6: A dispatched branch copies the map as it stands after its own rename. A mispredicted resolve restores that copy, sets the next slot to the branch slot plus one, and frees the physical registers of all younger entries. A correct resolve keeps every entry.
- R7: Dispatch is refused while the ROB holds 8 entries, while a destination is needed and no physical register is free, or while a branch arrives and both map copies are in use.
- R8: Dispatch is refused in any cycle with a resolve.
- R9: A resolved branch counts as completed and commits without a separate completion report.
- R10: A mispredicted resolve also releases the map copies of any younger branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_op | input | 4 | Opcode, stored and returned at commit |
| disp_src1 | input | 3 | First source architectural register |
| disp_src2 | input | 3 | Second source architectural register |
| disp_dst | input | 3 | Destination architectural register |
| disp_has_dst | input | 1 | Instruction writes a destination |
| disp_branch | input | 1 | Instruction is a branch |
| disp_ready | output | 1 | Dispatch accepted this cycle when valid |
| disp_tag | output | 3 | ROB slot given to the dispatched instruction |
| ren_src1 | output | 4 | Physical tag of the first source |
| ren_src1_rdy | output | 1 | First source value available |
| ren_src2 | output | 4 | Physical tag of the second source |
| ren_src2_rdy | output | 1 | Second source value available |
| ren_dst | output | 4 | Physical register allocated to the destination |
| exec_valid | input | 1 | Completion report |
| exec_tag | input | 3 | ROB slot that completed |
| res_valid | input | 1 | Branch resolve |
| res_tag | input | 3 | ROB slot of the resolved branch |
| res_mispredict | input | 1 | Resolved branch was mispredicted |
| cmt_valid | output | 1 | Oldest entry commits this cycle |
| cmt_tag | output | 3 | ROB slot committing |
| cmt_op | output | 4 | Opcode of the committing entry |
| cmt_dst | output | 3 | Destination architectural register |
| cmt_has_dst | output | 1 | Committing entry had a destination |
| cmt_free_preg | output | 4 | Previous mapping released to the free list |

## Verification
The bench reports completion on a later entry while the oldest entry is still pending. A design that retired out of order would then offer a commit too early. It reads a source in the same cycle that source is being woken, which exposes a missing bypass as a false not-ready flag. It mispredicts a branch that has younger allocating entries and a younger branch behind it. It then checks that the restored map, the rolled-back slot number, the reuse of the lowest freed register, and the ability to take two new branches all come out right. A design that leaked registers, kept stale mappings or held on to the younger branch's copy would fail one of these checks. It also fills the ROB and both map copies to show the stall conditions, and retires a resolved branch that never received a completion report.

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_ARCH  = 8,
  parameter int NUM_PHYS  = 16,
  parameter int ROB_DEPTH = 8,
  parameter int NUM_SNAP  = 2,
  parameter int OP_W      = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int RW = $clog2(ROB_DEPTH),
  localparam int SW = (NUM_SNAP > 1) ? $clog2(NUM_SNAP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  input  logic [OP_W-1:0] disp_op,
  input  logic [AW-1:0]   disp_src1,
  input  logic [AW-1:0]   disp_src2,
  input  logic [AW-1:0]   disp_dst,
  input  logic            disp_has_dst,
  input  logic            disp_branch,
  output logic            disp_ready,
  output logic [RW-1:0]   disp_tag,
  output logic [PW-1:0]   ren_src1,
  output logic            ren_src1_rdy,
  output logic [PW-1:0]   ren_src2,
  output logic            ren_src2_rdy,
  output logic [PW-1:0]   ren_dst,
  input  logic            exec_valid,
  input  logic [RW-1:0]   exec_tag,
  input  logic            res_valid,
  input  logic [RW-1:0]   res_tag,
  input  logic            res_mispredict,
  output logic            cmt_valid,
  output logic [RW-1:0]   cmt_tag,
  output logic [OP_W-1:0] cmt_op,
  output logic [AW-1:0]   cmt_dst,
  output logic            cmt_has_dst,
  output logic [PW-1:0]   cmt_free_preg
);

  logic [PW-1:0]        map_q [NUM_ARCH];
  logic [NUM_PHYS-1:0]  free_q, rdy_q;
  logic [NUM_SNAP-1:0]  snap_v;
  logic [RW-1:0]        snap_tag [NUM_SNAP];
  logic [PW-1:0]        snap_map [NUM_SNAP][NUM_ARCH];

  logic [ROB_DEPTH-1:0] use_q, ex_q, hd_q;
  logic [OP_W-1:0]      op_q  [ROB_DEPTH];
  logic [AW-1:0]        dst_q [ROB_DEPTH];
  logic [PW-1:0]        old_q [ROB_DEPTH];
  logic [PW-1:0]        new_q [ROB_DEPTH];
  logic [RW-1:0]        head_q, tail_q;
  logic [RW:0]          cnt_q;

  logic          alloc_ok, slot_ok, hit_ok, full, fire, mis, exec_wake;
  logic [PW-1:0] alloc_p, exec_p;
  logic [SW-1:0] slot_i, hit_i;
  logic [RW-1:0] br_age;

  always_comb begin
    alloc_ok = 1'b0;
    alloc_p  = '0;
    for (int p = NUM_PHYS - 1; p >= 0; p--)
      if (free_q[p]) begin
        alloc_ok = 1'b1;
        alloc_p  = PW'(p);
      end
  end

  always_comb begin
    slot_ok = 1'b0;
    slot_i  = '0;
    hit_ok  = 1'b0;
    hit_i   = '0;
    for (int s = NUM_SNAP - 1; s >= 0; s--) begin
      if (!snap_v[s]) begin
        slot_ok = 1'b1;
        slot_i  = SW'(s);
      end
      if (snap_v[s] && snap_tag[s] == res_tag) begin
        hit_ok = 1'b1;
        hit_i  = SW'(s);
      end
    end
  end

  assign full       = cnt_q == (RW+1)'(ROB_DEPTH);
  assign disp_ready = !res_valid && !full && (alloc_ok || !disp_has_dst) && (slot_ok || !disp_branch);
  assign fire       = disp_valid && disp_ready;
  assign disp_tag   = tail_q;
  assign ren_dst    = alloc_p;

  assign exec_wake    = exec_valid && use_q[exec_tag] && hd_q[exec_tag];
  assign exec_p       = new_q[exec_tag];
  assign ren_src1     = map_q[disp_src1];
  assign ren_src2     = map_q[disp_src2];
  assign ren_src1_rdy = rdy_q[ren_src1] || (exec_wake && exec_p == ren_src1);
  assign ren_src2_rdy = rdy_q[ren_src2] || (exec_wake && exec_p == ren_src2);

  assign cmt_valid     = use_q[head_q] && ex_q[head_q];
  assign cmt_tag       = head_q;
  assign cmt_op        = op_q[head_q];
  assign cmt_dst       = dst_q[head_q];
  assign cmt_has_dst   = hd_q[head_q];
  assign cmt_free_preg = old_q[head_q];

  assign mis    = res_valid && res_mispredict && hit_ok;
  assign br_age = res_tag - head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(a);
      for (int p = 0; p < NUM_PHYS; p++) begin
        free_q[p] <= (p >= NUM_ARCH);
        rdy_q[p]  <= (p < NUM_ARCH);
      end
      use_q  <= '0;
      ex_q   <= '0;
      snap_v <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (exec_valid && use_q[exec_tag]) begin
        ex_q[exec_tag] <= 1'b1;
        if (hd_q[exec_tag]) rdy_q[exec_p] <= 1'b1;
      end
      if (res_valid && hit_ok) begin
        ex_q[res_tag]  <= 1'b1;
        snap_v[hit_i]  <= 1'b0;
      end
      if (cmt_valid) begin
        use_q[head_q] <= 1'b0;
        if (hd_q[head_q]) free_q[old_q[head_q]] <= 1'b1;
        head_q <= head_q + RW'(1);
      end
      if (mis) begin
        for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= snap_map[hit_i][a];
        for (int s = 0; s < NUM_SNAP; s++)
          if (snap_v[s] && (snap_tag[s] - head_q) > br_age) snap_v[s] <= 1'b0;
        for (int i = 0; i < ROB_DEPTH; i++)
          if (use_q[i] && (RW'(i) - head_q) > br_age) begin
            use_q[i] <= 1'b0;
            if (hd_q[i]) free_q[new_q[i]] <= 1'b1;
          end
        tail_q <= res_tag + RW'(1);
        cnt_q  <= (RW+1)'(br_age) + (RW+1)'(1) - (RW+1)'(cmt_valid);
      end else begin
        tail_q <= tail_q + RW'(fire);
        cnt_q  <= cnt_q + (RW+1)'(fire) - (RW+1)'(cmt_valid);
      end
      if (fire) begin
        use_q[tail_q] <= 1'b1;
        ex_q[tail_q]  <= 1'b0;
        if (disp_has_dst) begin
          map_q[disp_dst] <= alloc_p;
          free_q[alloc_p] <= 1'b0;
          rdy_q[alloc_p]  <= 1'b0;
        end
        if (disp_branch) snap_v[slot_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      op_q[tail_q]  <= disp_op;
      dst_q[tail_q] <= disp_dst;
      hd_q[tail_q]  <= disp_has_dst;
      old_q[tail_q] <= map_q[disp_dst];
      new_q[tail_q] <= alloc_p;
      if (disp_branch) begin
        snap_tag[slot_i] <= tail_q;
        for (int a = 0; a < NUM_ARCH; a++)
          snap_map[slot_i][a] <= (disp_has_dst && AW'(a) == disp_dst) ? alloc_p : map_q[a];
      end
    end
  end

endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int NUM_PHYS  = 16,
  parameter int ROB_DEPTH = 8,
  parameter int PW = 4,
  parameter int RW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                disp_valid,
  input logic                disp_ready,
  input logic                disp_has_dst,
  input logic [PW-1:0]       ren_dst,
  input logic                res_valid,
  input logic                cmt_valid,
  input logic [RW-1:0]       head_q,
  input logic [RW:0]         cnt_q,
  input logic [NUM_PHYS-1:0] free_q,
  input logic [NUM_PHYS-1:0] rdy_q,
  input logic                exec_wake,
  input logic [PW-1:0]       exec_p
);

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == (RW+1)'(ROB_DEPTH) |-> !disp_ready);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (RW+1)'(ROB_DEPTH));

  a_r8_resolve_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !disp_ready);

  a_r2_alloc_leaves_free: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_has_dst) |=> !free_q[$past(ren_dst)]);

  a_r3_alloc_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_has_dst) |=> !rdy_q[$past(ren_dst)]);

  a_r4_wake_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    exec_wake |=> rdy_q[$past(exec_p)]);

  a_r5_commit_advances: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> head_q == $past(head_q) + RW'(1));

  a_r5_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_valid |=> $stable(head_q));

endmodule

bind rename_unit rename_unit_chk #(
  .NUM_PHYS(NUM_PHYS), .ROB_DEPTH(ROB_DEPTH), .PW(PW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_has_dst(disp_has_dst), .ren_dst(ren_dst), .res_valid(res_valid),
  .cmt_valid(cmt_valid), .head_q(head_q), .cnt_q(cnt_q), .free_q(free_q),
  .rdy_q(rdy_q), .exec_wake(exec_wake), .exec_p(exec_p)
);

// File: tb/test_rename_unit.sv
`timescale 1ns/1ps
module test_rename_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic       disp_valid, disp_has_dst, disp_branch;
  logic [3:0] disp_op;
  logic [2:0] disp_src1, disp_src2, disp_dst;
  logic       disp_ready, ren_src1_rdy, ren_src2_rdy;
  logic [2:0] disp_tag;
  logic [3:0] ren_src1, ren_src2, ren_dst;
  logic       exec_valid, res_valid, res_mispredict;
  logic [2:0] exec_tag, res_tag;
  logic       cmt_valid, cmt_has_dst;
  logic [2:0] cmt_tag, cmt_dst;
  logic [3:0] cmt_op, cmt_free_preg;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rename_unit i_rename_unit (.*);

  // s1, s2, dst, exp s1 preg, s1 rdy, exp s2 preg, s2 rdy, exp dst preg, exp tag
  localparam int VEC [4][9] = '{
    '{2, 3, 1,  2, 1,  3, 1,   8, 0},
    '{1, 1, 2,  8, 0,  8, 0,   9, 1},
    '{2, 1, 1,  9, 0,  8, 0,  10, 2},
    '{4, 0, 3,  4, 1,  0, 1,  11, 3}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    disp_valid = 0; disp_has_dst = 0; disp_branch = 0; disp_op = 0;
    disp_src1 = 0; disp_src2 = 0; disp_dst = 0;
    exec_valid = 0; exec_tag = 0; res_valid = 0; res_tag = 0; res_mispredict = 0;
  endtask

  task automatic disp(input int s1, input int s2, input int d, input bit hd, input bit br, input int op);
    disp_valid = 1; disp_src1 = 3'(s1); disp_src2 = 3'(s2); disp_dst = 3'(d);
    disp_has_dst = hd; disp_branch = br; disp_op = 4'(op);
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("[TB] FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    cyc(); #1;
    chk("R1 ready after reset", disp_ready, 1);
    chk("R1 first slot", disp_tag, 0);
    chk("R1 no commit", cmt_valid, 0);

    for (int k = 0; k < 4; k++) begin
      cyc();
      disp(VEC[k][0], VEC[k][1], VEC[k][2], 1, 0, k + 1);
      #1;
      chk("R2 src1 tag", ren_src1, VEC[k][3]);
      chk("R3 src1 rdy", ren_src1_rdy, VEC[k][4]);
      chk("R2 src2 tag", ren_src2, VEC[k][5]);
      chk("R3 src2 rdy", ren_src2_rdy, VEC[k][6]);
      chk("R2 dst alloc", ren_dst, VEC[k][7]);
      chk("R2 slot", disp_tag, VEC[k][8]);
    end

    cyc(); exec_valid = 1; exec_tag = 0; #1;
    chk("R5 no commit before done", cmt_valid, 0);

    cyc(); exec_valid = 1; exec_tag = 1; disp(2, 7, 6, 1, 0, 5); #1;
    chk("R4 bypass wake", ren_src1_rdy, 1);
    chk("R4 bypass tag", ren_src1, 9);
    chk("R2 dst alloc p12", ren_dst, 12);
    chk("R5 commit slot0", cmt_valid, 1);
    chk("R5 commit dst", cmt_dst, 1);
    chk("R5 commit old map", cmt_free_preg, 1);
    chk("R5 commit op", cmt_op, 1);

    cyc(); disp(1, 0, 7, 1, 0, 6); #1;
    chk("R3 pending src", ren_src1_rdy, 0);
    chk("R5 freed reused", ren_dst, 1);
    chk("R2 slot5", disp_tag, 5);
    chk("R5 commit slot1", cmt_tag, 1);
    chk("R5 commit old map2", cmt_free_preg, 2);

    cyc(); exec_valid = 1; exec_tag = 3; disp(1, 0, 0, 0, 1, 7); #1;
    chk("R6 branch accepted", disp_ready, 1);
    chk("R2 branch slot", disp_tag, 6);

    cyc(); disp(2, 2, 1, 1, 0, 8); #1;
    chk("R5 in order hold", cmt_valid, 0);
    chk("R4 woken earlier", ren_src1_rdy, 1);
    chk("R2 dst p2", ren_dst, 2);
    chk("R2 slot7", disp_tag, 7);

    cyc(); disp(1, 1, 2, 1, 0, 9); #1;
    chk("R2 sees new map", ren_src1, 2);
    chk("R2 dst p13", ren_dst, 13);
    chk("R2 slot wraps", disp_tag, 0);

    cyc(); res_valid = 1; res_tag = 6; res_mispredict = 1; #1;
    chk("R8 resolve blocks", disp_ready, 0);

    cyc(); disp(1, 2, 3, 1, 0, 10); #1;
    chk("R6 restored src1", ren_src1, 10);
    chk("R6 restored src2", ren_src2, 9);
    chk("R6 flushed reg reused", ren_dst, 2);
    chk("R6 slot rolled back", disp_tag, 7);

    cyc(); disp(0, 0, 0, 0, 0, 11); #1;
    chk("R2 slot0 again", disp_tag, 0);
    cyc(); disp(0, 0, 0, 0, 0, 12); #1;
    chk("R7 last slot ok", disp_ready, 1);

    cyc(); exec_valid = 1; exec_tag = 2; disp(0, 0, 0, 0, 0, 13); #1;
    chk("R7 full stalls", disp_ready, 0);

    cyc(); exec_valid = 1; exec_tag = 4; #1;
    chk("R5 commit slot2", cmt_tag, 2);
    chk("R5 commit slot2 old", cmt_free_preg, 8);
    chk("R5 commit slot2 op", cmt_op, 3);
    cyc(); exec_valid = 1; exec_tag = 5; #1;
    chk("R5 commit slot3 old", cmt_free_preg, 3);
    cyc(); #1;
    chk("R5 commit slot4 old", cmt_free_preg, 6);
    cyc(); #1;
    chk("R5 commit slot5 old", cmt_free_preg, 7);
    cyc(); #1;
    chk("R9 branch commits", cmt_valid, 1);
    chk("R9 branch slot", cmt_tag, 6);
    chk("R9 branch no dst", cmt_has_dst, 0);
    cyc(); #1;
    chk("R5 waits on slot7", cmt_valid, 0);

    do_reset();
    cyc(); disp(0, 0, 0, 0, 1, 1); #1;
    chk("R1 branch slot0", disp_tag, 0);
    cyc(); disp(0, 0, 0, 0, 1, 2); #1;
    chk("R6 second branch ok", disp_ready, 1);
    cyc(); disp_branch = 1; #1;
    chk("R7 no copy stalls", disp_ready, 0);
    disp_branch = 0; disp_has_dst = 1; #1;
    chk("R7 non-branch ok", disp_ready, 1);
    cyc(); disp(1, 1, 1, 1, 0, 3); #1;
    chk("R2 after reset src", ren_src1, 1);
    chk("R2 alloc p8", ren_dst, 8);
    chk("R2 slot2", disp_tag, 2);
    cyc(); res_valid = 1; res_tag = 0; res_mispredict = 1; #1;
    chk("R8 blocks on mispredict", disp_ready, 0);
    cyc(); disp(0, 0, 0, 0, 1, 4); #1;
    chk("R6 rollback slot1", disp_tag, 1);
    chk("R6 branch after flush", disp_ready, 1);
    cyc(); disp(0, 0, 0, 0, 1, 5); #1;
    chk("R10 younger copy released", disp_ready, 1);
    chk("R10 slot2", disp_tag, 2);
    cyc(); disp(1, 1, 4, 1, 0, 6); #1;
    chk("R6 map restored", ren_src1, 1);
    chk("R6 restored rdy", ren_src1_rdy, 1);
    chk("R6 freed p8 reused", ren_dst, 8);
    cyc(); res_valid = 1; res_tag = 2; res_mispredict = 0; #1;
    chk("R8 blocks on correct resolve", disp_ready, 0);
    cyc(); disp(0, 0, 0, 0, 1, 7); #1;
    chk("R6 correct keeps entries", disp_tag, 4);
    chk("R6 copy released", disp_ready, 1);
    cyc(); disp_branch = 1; #1;
    chk("R7 copies full again", disp_ready, 0);

    cyc();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule